// File: doc/BRIEF.md
# Segment Selector Load Unit

This block services writes of a 16-bit selector into one of four segment registers and keeps, next to each register, a hidden copy of the segment's base, limit and privilege level. Address translation reads that hidden copy through a read port, so the descriptor table in memory is touched only when a register is loaded, never on each access.

In protected mode a load decodes the selector. Bits 15:3 are the table index, bit 2 picks the table (0 for the global table, 1 for the local table), and bits 1:0 are the requested privilege level. The unit forms the descriptor address and fetches the 8-byte record as two 32-bit reads over a simple request/response port. It stays busy until both words have returned. In real mode a load completes in one cycle with no memory traffic. A null selector loaded into a data register only invalidates that register's cache entry. Register 0 is the code register, and it accepts only loads tagged as control flow.

Register numbering: 0 code, 1 stack, 2 and 3 data. The global table base is a register inside the unit. The local table base is an input.

Top module: `seg_load_unit`

## Requirements
- R1: A protected-mode load of a non-null selector reads the descriptor at table base + index*8, where index is selector bits 15:3 and bit 2 selects the base (0: global register, 1: `ldt_base_i`). The first request is presented the cycle after the load is accepted. The second request is at that address + 4.
- R2: The word at the lower address is the segment base. In the upper word, bits 19:0 are the limit and bits 21:20 are the privilege level. After the fetch, the entry holds these values, the selector, and valid = 1.
- R3: `busy_o` is high from the cycle after a fetching load is accepted until the fetch ends. Loads offered while busy are ignored. `mem_req_o` and `mem_addr_o` hold steady until `mem_rvalid_i` is seen.
- R4: `done_o` is high for exactly the one cycle after the second read response. In that same cycle `busy_o` is low and the new entry is readable. `done_o` and `err_o` are never high together.
- R5: A load into register 0 without `load_ctrl_i` raises `err_o` for one cycle, in either mode. It leaves the cache unchanged and issues no memory read.
- R6: A real-mode load sets base = selector*16, limit = 0xFFFF, privilege 0 and valid = 1. `done_o` follows one cycle later, with no memory read.
- R7: A protected-mode null selector (index 0, table bit 0) clears the valid bit of a data register (2 or 3), with no read and `done_o` one cycle later. The same selector into register 0 or 1 raises `err_o` instead.
- R8: Cached values persist. Later changes of either table base do not alter loaded entries.
- R9: The global base register resets to 0 and takes `gdt_base_i` when `gdt_base_we_i` is high.
- R10: After reset, every entry reads as all zero with valid = 0, and `busy_o`, `done_o`, `err_o` and `mem_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| prot_mode_i | input | 1 | 1: protected mode, 0: real mode |
| gdt_base_we_i | input | 1 | Write enable of the global table base register |
| gdt_base_i | input | 32 | New global table base |
| ldt_base_i | input | 32 | Local table base |
| load_valid_i | input | 1 | Load request |
| load_seg_i | input | 2 | Target register (0 code, 1 stack, 2/3 data) |
| load_sel_i | input | 16 | Selector to load |
| load_ctrl_i | input | 1 | Load comes from a call or jump |
| busy_o | output | 1 | Descriptor fetch in progress |
| done_o | output | 1 | Load completed (one-cycle pulse) |
| err_o | output | 1 | Load rejected (one-cycle pulse) |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Memory read address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data |
| rd_seg_i | input | 2 | Register whose cache entry is read |
| rd_valid_o | output | 1 | Entry valid |
| rd_sel_o | output | 16 | Selector held |
| rd_base_o | output | 32 | Cached base |
| rd_limit_o | output | 20 | Cached limit |
| rd_dpl_o | output | 2 | Cached privilege level |

## Verification
A real-mode load, a null load or a rejected load shows its result on `done_o` or `err_o`, and in the cache, in the cycle right after the accepting edge. A fetching load shows its first request in that same cycle. Each word is consumed on the edge where `mem_rvalid_i` is high, and the done pulse and new entry appear in the cycle after the second response. The bench drives every input at the falling edge and samples at the following falling edge. It waits for a variable number of cycles before each response and checks that the request is held through the wait. It then counts exactly one edge from the response to the done check.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int unsigned SEL_W      = 16;
  localparam int unsigned ADDR_W     = 32;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned LIM_W      = 20;
  localparam int unsigned DPL_W      = 2;
  localparam int unsigned IDX_LSB    = 3;
  localparam int unsigned TI_BIT     = 2;
  localparam int unsigned DPL_LSB    = 20;
  localparam int unsigned REAL_SHIFT = 4;
  localparam int unsigned WORD_BYTES = DATA_W / 8;
  localparam logic [LIM_W-1:0] REAL_LIMIT = LIM_W'(16'hFFFF);

  typedef struct packed {
    logic              valid;
    logic [SEL_W-1:0]  sel;
    logic [ADDR_W-1:0] base;
    logic [LIM_W-1:0]  limit;
    logic [DPL_W-1:0]  dpl;
  } seg_entry_t;

  typedef enum logic [1:0] {FS_IDLE, FS_LO, FS_HI} fetch_state_e;
endpackage

// File: rtl/seg_sel_decode.sv
module seg_sel_decode
  import seg_pkg::*;
(
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [ADDR_W-1:0] gdt_base_i,
  input  logic [ADDR_W-1:0] ldt_base_i,
  output logic              null_o,
  output logic [ADDR_W-1:0] desc_addr_o
);
  localparam int unsigned IDX_W = SEL_W - IDX_LSB;

  logic [IDX_W-1:0]  idx;
  logic              ti;
  logic [ADDR_W-1:0] tbl_base;
  logic [ADDR_W-1:0] idx_off;

  assign idx      = sel_i[SEL_W-1:IDX_LSB];
  assign ti       = sel_i[TI_BIT];
  assign null_o   = (idx == '0) && !ti;
  assign tbl_base = ti ? ldt_base_i : gdt_base_i;
  // 8-byte records: index scaled by the low selector field width
  assign idx_off  = {{(ADDR_W-IDX_W){1'b0}}, idx} << IDX_LSB;
  assign desc_addr_o = tbl_base + idx_off;
endmodule

// File: rtl/seg_desc_fetch.sv
module seg_desc_fetch
  import seg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic              busy_o,
  output logic              wr_o,
  output logic [ADDR_W-1:0] base_o,
  output logic [LIM_W-1:0]  limit_o,
  output logic [DPL_W-1:0]  dpl_o
);
  fetch_state_e      state_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] lo_q;
  logic              unused_hi;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= FS_IDLE;
      addr_q  <= '0;
      lo_q    <= '0;
    end else begin
      unique case (state_q)
        FS_IDLE: if (start_i) begin
          state_q <= FS_LO;
          addr_q  <= addr_i;
        end
        FS_LO: if (mem_rvalid_i) begin
          state_q <= FS_HI;
          lo_q    <= mem_rdata_i;
          addr_q  <= addr_q + ADDR_W'(WORD_BYTES);
        end
        FS_HI: if (mem_rvalid_i) state_q <= FS_IDLE;
        default: state_q <= FS_IDLE;
      endcase
    end
  end

  assign busy_o     = (state_q != FS_IDLE);
  assign mem_req_o  = busy_o;
  assign mem_addr_o = addr_q;
  assign wr_o       = (state_q == FS_HI) && mem_rvalid_i;
  assign base_o     = lo_q[ADDR_W-1:0];
  assign limit_o    = mem_rdata_i[LIM_W-1:0];
  assign dpl_o      = mem_rdata_i[DPL_LSB +: DPL_W];
  assign unused_hi  = ^mem_rdata_i[DATA_W-1:DPL_LSB+DPL_W];
endmodule

// File: rtl/seg_cache.sv
module seg_cache
  import seg_pkg::*;
#(
  parameter int unsigned NUM_SEG = 4,
  localparam int unsigned SEG_W  = $clog2(NUM_SEG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [SEG_W-1:0] widx_i,
  input  seg_entry_t       wentry_i,
  input  logic [SEG_W-1:0] ridx_i,
  output seg_entry_t       rentry_o
);
  seg_entry_t entry_q [NUM_SEG];

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) entry_q[g] <= '0;
      else if (we_i && (widx_i == SEG_W'(g))) entry_q[g] <= wentry_i;
    end
  end

  assign rentry_o = entry_q[ridx_i];
endmodule

// File: rtl/seg_load_unit.sv
module seg_load_unit
  import seg_pkg::*;
#(
  parameter int unsigned NUM_SEG   = 4,
  parameter int unsigned CODE_IDX  = 0,
  parameter int unsigned STACK_IDX = 1,
  localparam int unsigned SEG_W    = $clog2(NUM_SEG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              prot_mode_i,
  input  logic              gdt_base_we_i,
  input  logic [ADDR_W-1:0] gdt_base_i,
  input  logic [ADDR_W-1:0] ldt_base_i,
  input  logic              load_valid_i,
  input  logic [SEG_W-1:0]  load_seg_i,
  input  logic [SEL_W-1:0]  load_sel_i,
  input  logic              load_ctrl_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_rvalid_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic [SEG_W-1:0]  rd_seg_i,
  output logic              rd_valid_o,
  output logic [SEL_W-1:0]  rd_sel_o,
  output logic [ADDR_W-1:0] rd_base_o,
  output logic [LIM_W-1:0]  rd_limit_o,
  output logic [DPL_W-1:0]  rd_dpl_o
);
  logic [ADDR_W-1:0] gdt_q;
  logic              sel_null;
  logic [ADDR_W-1:0] desc_addr;
  logic              fetch_busy, fetch_wr;
  logic [ADDR_W-1:0] f_base;
  logic [LIM_W-1:0]  f_limit;
  logic [DPL_W-1:0]  f_dpl;
  logic              accept, is_code, is_stack, reject, direct, start;
  logic [SEG_W-1:0]  pend_seg_q;
  logic [SEL_W-1:0]  pend_sel_q;
  logic              done_q, err_q;
  seg_entry_t        direct_entry, wentry, rentry;
  logic              we;
  logic [SEG_W-1:0]  widx;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            gdt_q <= '0;
    else if (gdt_base_we_i) gdt_q <= gdt_base_i;
  end

  seg_sel_decode i_decode (
    .sel_i       (load_sel_i),
    .gdt_base_i  (gdt_q),
    .ldt_base_i  (ldt_base_i),
    .null_o      (sel_null),
    .desc_addr_o (desc_addr)
  );

  assign accept   = load_valid_i && !fetch_busy;
  assign is_code  = (load_seg_i == SEG_W'(CODE_IDX));
  assign is_stack = (load_seg_i == SEG_W'(STACK_IDX));
  // code register takes only control-flow loads; null is invalid for code/stack
  assign reject   = accept && ((is_code && !load_ctrl_i) ||
                               (prot_mode_i && sel_null && (is_code || is_stack)));
  assign direct   = accept && !reject && (!prot_mode_i || sel_null);
  assign start    = accept && !reject && prot_mode_i && !sel_null;

  seg_desc_fetch i_fetch (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .addr_i       (desc_addr),
    .mem_req_o    (mem_req_o),
    .mem_addr_o   (mem_addr_o),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_rdata_i  (mem_rdata_i),
    .busy_o       (fetch_busy),
    .wr_o         (fetch_wr),
    .base_o       (f_base),
    .limit_o      (f_limit),
    .dpl_o        (f_dpl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_seg_q <= '0;
      pend_sel_q <= '0;
      done_q     <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      if (start) begin
        pend_seg_q <= load_seg_i;
        pend_sel_q <= load_sel_i;
      end
      done_q <= direct || fetch_wr;
      err_q  <= reject;
    end
  end

  always_comb begin
    direct_entry       = '0;
    direct_entry.sel   = load_sel_i;
    direct_entry.valid = !prot_mode_i;
    if (!prot_mode_i) begin
      direct_entry.base  = {{(ADDR_W-SEL_W){1'b0}}, load_sel_i} << REAL_SHIFT;
      direct_entry.limit = REAL_LIMIT;
    end
  end

  always_comb begin
    if (fetch_wr) begin
      wentry = '{valid: 1'b1, sel: pend_sel_q, base: f_base, limit: f_limit, dpl: f_dpl};
      widx   = pend_seg_q;
    end else begin
      wentry = direct_entry;
      widx   = load_seg_i;
    end
  end
  assign we = direct || fetch_wr;

  seg_cache #(.NUM_SEG(NUM_SEG)) i_cache (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (we),
    .widx_i   (widx),
    .wentry_i (wentry),
    .ridx_i   (rd_seg_i),
    .rentry_o (rentry)
  );

  assign busy_o     = fetch_busy;
  assign done_o     = done_q;
  assign err_o      = err_q;
  assign rd_valid_o = rentry.valid;
  assign rd_sel_o   = rentry.sel;
  assign rd_base_o  = rentry.base;
  assign rd_limit_o = rentry.limit;
  assign rd_dpl_o   = rentry.dpl;
endmodule

// File: rtl/seg_load_chk.sv
module seg_load_chk
  import seg_pkg::*;
#(
  parameter int unsigned CODE_IDX = 0,
  parameter int unsigned SEG_W    = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              prot_mode_i,
  input logic              load_valid_i,
  input logic [SEG_W-1:0]  load_seg_i,
  input logic [SEL_W-1:0]  load_sel_i,
  input logic              load_ctrl_i,
  input logic              busy_o,
  input logic              done_o,
  input logic              err_o,
  input logic              mem_req_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_rvalid_i
);
  logic code_move, nonnull;
  assign code_move = (load_seg_i == SEG_W'(CODE_IDX)) && !load_ctrl_i;
  assign nonnull   = (load_sel_i[SEL_W-1:TI_BIT] != '0);

  AST_NEW_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_valid_i && !busy_o && prot_mode_i && nonnull && !code_move
    |=> busy_o && mem_req_o);  // R1

  AST_REQ_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o));  // R3

  AST_DONE_AFTER_RESP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && $past(busy_o) |-> $past(mem_rvalid_i) && !busy_o);  // R4

  AST_DONE_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && err_o));  // R4

  AST_CODE_MOVE_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_valid_i && !busy_o && code_move |=> err_o && !busy_o && !mem_req_o);  // R5

  AST_REAL_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_valid_i && !busy_o && !prot_mode_i && !code_move |=> done_o && !mem_req_o);  // R6
endmodule

bind seg_load_unit seg_load_chk #(.CODE_IDX(CODE_IDX), .SEG_W(SEG_W)) i_seg_load_chk (.*);

// File: tb/test_seg_load_unit.sv
module test_seg_load_unit;
  import seg_pkg::*;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        prot_mode_i = 1'b0;
  logic        gdt_base_we_i = 1'b0;
  logic [31:0] gdt_base_i = '0;
  logic [31:0] ldt_base_i = 32'h0020_4000;
  logic        load_valid_i = 1'b0;
  logic [1:0]  load_seg_i = '0;
  logic [15:0] load_sel_i = '0;
  logic        load_ctrl_i = 1'b0;
  logic        busy_o, done_o, err_o, mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_rvalid_i = 1'b0;
  logic [31:0] mem_rdata_i = '0;
  logic [1:0]  rd_seg_i = '0;
  logic        rd_valid_o;
  logic [15:0] rd_sel_o;
  logic [31:0] rd_base_o;
  logic [19:0] rd_limit_o;
  logic [1:0]  rd_dpl_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] gdt_model = '0;

  logic        e_valid [4];
  logic [15:0] e_sel   [4];
  logic [31:0] e_base  [4];
  logic [19:0] e_lim   [4];
  logic [1:0]  e_dpl   [4];

  seg_load_unit i_seg_load_unit (.*);

  always #2 clk_i = ~clk_i;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h5A3C_96E1 ^ (a << 3);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic check_seg(input int s, input string tag);
    rd_seg_i = 2'(s);
    #1;
    chk({tag, " valid"}, 64'(rd_valid_o), 64'(e_valid[s]));
    chk({tag, " sel"},   64'(rd_sel_o),   64'(e_sel[s]));
    chk({tag, " base"},  64'(rd_base_o),  64'(e_base[s]));
    chk({tag, " limit"}, 64'(rd_limit_o), 64'(e_lim[s]));
    chk({tag, " dpl"},   64'(rd_dpl_o),   64'(e_dpl[s]));
  endtask

  task automatic check_all(input string tag);
    for (int s = 0; s < 4; s++) check_seg(s, tag);
  endtask

  // drive at a falling edge, return at the falling edge after the accepting edge
  task automatic issue(input int s, input logic [15:0] sel, input logic ctrl);
    load_valid_i = 1'b1;
    load_seg_i   = 2'(s);
    load_sel_i   = sel;
    load_ctrl_i  = ctrl;
    @(posedge clk_i);
    @(negedge clk_i);
    load_valid_i = 1'b0;
  endtask

  task automatic direct_load(input int s, input logic [15:0] sel, input logic ctrl,
                             input logic expect_err, input string tag);
    issue(s, sel, ctrl);
    chk({tag, " done"}, 64'(done_o), 64'(!expect_err));
    chk({tag, " err"},  64'(err_o),  64'(expect_err));
    chk({tag, " busy"}, 64'(busy_o), 64'd0);
    chk({tag, " req"},  64'(mem_req_o), 64'd0);
    if (!expect_err) begin
      e_sel[s] = sel;
      e_dpl[s] = '0;
      if (prot_mode_i) begin
        e_valid[s] = 1'b0; e_base[s] = '0; e_lim[s] = '0;
      end else begin
        e_valid[s] = 1'b1; e_base[s] = {16'd0, sel} << 4; e_lim[s] = 20'h0FFFF;
      end
    end
    check_all(tag);
    @(negedge clk_i);
    chk({tag, " pulse end"}, 64'({done_o, err_o}), 64'd0);
  endtask

  task automatic fetch_load(input int s, input logic [15:0] sel, input logic ctrl,
                            input int lat, input logic interfere);
    logic [31:0] a;
    logic [31:0] w;
    a = (sel[2] ? ldt_base_i : gdt_model) + ({19'd0, sel[15:3]} << 3);
    issue(s, sel, ctrl);
    chk("R3 busy after accept", 64'(busy_o), 64'd1);
    for (int k = 0; k < 2; k++) begin
      chk("R1 request", 64'(mem_req_o), 64'd1);
      chk("R1 address", 64'(mem_addr_o), 64'(a + 32'(4 * k)));
      for (int c = 0; c < lat; c++) begin
        if (interfere && k == 0 && c == 0) load_valid_i = 1'b1;
        load_seg_i = 2'(0); load_ctrl_i = 1'b0;
        @(posedge clk_i);
        @(negedge clk_i);
        load_valid_i = 1'b0;
        chk("R3 request held", 64'(mem_req_o), 64'd1);
        chk("R3 address held", 64'(mem_addr_o), 64'(a + 32'(4 * k)));
        chk("R3 load while busy ignored", 64'({err_o, done_o}), 64'd0);
      end
      w = mem_word(a + 32'(4 * k));
      mem_rvalid_i = 1'b1;
      mem_rdata_i  = w;
      @(posedge clk_i);
      @(negedge clk_i);
      mem_rvalid_i = 1'b0;
      mem_rdata_i  = '0;
      if (k == 0) begin
        chk("R3 busy between words", 64'(busy_o), 64'd1);
        chk("R4 no early done", 64'(done_o), 64'd0);
        e_base[s] = w;
      end else begin
        e_lim[s] = w[19:0];
        e_dpl[s] = w[21:20];
      end
    end
    chk("R4 done", 64'(done_o), 64'd1);
    chk("R4 busy low", 64'(busy_o), 64'd0);
    chk("R4 no err", 64'(err_o), 64'd0);
    e_valid[s] = 1'b1;
    e_sel[s]   = sel;
    check_all("R2 entry");
    @(negedge clk_i);
    chk("R4 single pulse", 64'(done_o), 64'd0);
  endtask

  initial begin
    for (int s = 0; s < 4; s++) begin
      e_valid[s] = 0; e_sel[s] = 0; e_base[s] = 0; e_lim[s] = 0; e_dpl[s] = 0;
    end
    repeat (3) @(negedge clk_i);
    chk("R10 busy", 64'(busy_o), 64'd0);
    chk("R10 req", 64'(mem_req_o), 64'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R10 flags", 64'({busy_o, done_o, err_o, mem_req_o}), 64'd0);
    check_all("R10 reset entry");

    // R9: global base resets to zero
    prot_mode_i = 1'b1;
    fetch_load(2, 16'h0008, 1'b0, 1, 1'b0);
    prot_mode_i = 1'b0;

    // R6: real-mode loads
    direct_load(1, 16'h1234, 1'b0, 1'b0, "R6 real stack");
    direct_load(2, 16'hFFFF, 1'b0, 1'b0, "R6 real top");
    direct_load(3, 16'h0000, 1'b0, 1'b0, "R6 real zero");
    direct_load(0, 16'h8001, 1'b1, 1'b0, "R6 real code ctrl");
    // R5: move-style code loads rejected in both modes
    direct_load(0, 16'h4321, 1'b0, 1'b1, "R5 real code move");

    // R9: write the global base
    gdt_base_i = 32'h0010_0000;
    gdt_base_we_i = 1'b1;
    @(negedge clk_i);
    gdt_base_we_i = 1'b0;
    gdt_model = 32'h0010_0000;

    prot_mode_i = 1'b1;
    direct_load(0, 16'h0018, 1'b0, 1'b1, "R5 prot code move");
    for (int idx = 0; idx < 32; idx++)
      for (int ti = 0; ti < 2; ti++)
        for (int s = 1; s < 4; s++)
          if (idx != 0 || ti != 0)
            fetch_load(s, {13'(idx), 1'(ti), 2'(idx % 4)}, 1'b0, (idx + s) % 3,
                       idx == 5 && s == 2);
    fetch_load(0, 16'hFFFF, 1'b1, 2, 1'b0);
    fetch_load(1, 16'hFFF8, 1'b0, 0, 1'b0);

    // R7: null selectors
    direct_load(2, 16'h0003, 1'b0, 1'b0, "R7 null data2");
    direct_load(3, 16'h0000, 1'b0, 1'b0, "R7 null data3");
    direct_load(1, 16'h0002, 1'b0, 1'b1, "R7 null stack");
    direct_load(0, 16'h0000, 1'b1, 1'b1, "R7 null code");

    // R8: later base changes leave loaded entries alone
    fetch_load(2, 16'h0048, 1'b0, 1, 1'b0);
    gdt_base_i = 32'h0777_0000;
    gdt_base_we_i = 1'b1;
    ldt_base_i = 32'h0333_0000;
    @(negedge clk_i);
    gdt_base_we_i = 1'b0;
    gdt_model = 32'h0777_0000;
    @(negedge clk_i);
    check_all("R8 persist");
    fetch_load(3, 16'h0050, 1'b0, 0, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule